// File: doc/BRIEF.md
# Sliding-Window Image Line Buffer

This block turns a raster stream of 12-bit pixels, one per accepted cycle, into a square window of pixels for a convolution datapath. It is built for one input channel. The column position counts up to a programmable image width and then wraps. A line store keeps, for every column, the pixels of the six rows above the current one. When a pixel arrives, the block reads the stored column at that position and appends the new pixel to form a full column. That column shifts into the right edge of a 7x7 register window, and the same column, less its oldest pixel, is written back to the store.

The block therefore reuses six of every seven window columns from registers and all the rows above from the store. Only one new pixel enters per cycle. Stored rows stay in place when the scan wraps to the next line, so a new line never needs a reload.

The kernel size can be 3, 5 or 7. The active taps are the bottom-right KxK square of the window, and all other taps read zero. The window output is registered and carries a valid flag. A downstream stall holds the window and closes the input.

Top module: `lb_sliding_window`

## Requirements
- R1: While reset is active and right after it, out_valid is 0 and in_ready is 1.
- R2: A pixel is taken in a cycle where in_valid and in_ready are both 1. From the next cycle it appears at the bottom-right tap (row 6, column 6), whatever the kernel size.
- R3: Number the most recently taken pixel as image row y, column x. Tap (r, c) occupies out_window bits [(r*7+c)*12 +: 12], with r=0 the top row and c=0 the left column. When the tap is active, it holds the pixel at row y-6+r, column x-6+c.
- R4: cfg_kernel selects K: 0 gives 3, 1 gives 5, and 2 or 3 give 7. Taps with r < 7-K or c < 7-K read zero.
- R5: Taking pixel (y, x) makes out_valid 1 in the next cycle exactly when y >= K-1 and x >= K-1. Row y counts from 0 at reset.
- R6: cfg_width holds the image width W as a plain binary value from 1 to 1024. The column after W-1 is 0 of the next row, and the rows in the store are kept across that wrap.
- R7: While out_valid is 1 and out_ready is 0, in_ready is 0, and out_valid and out_window hold their values.
- R8: If out_valid is 1, out_ready is 1 and no pixel is taken, out_valid is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_width | input | 11 | Image width W, from 1 to 1024 |
| cfg_kernel | input | 2 | Kernel size select |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Block can take a pixel |
| in_pixel | input | 12 | Input pixel |
| out_valid | output | 1 | Window is complete |
| out_ready | input | 1 | Downstream takes the window |
| out_window | output | 588 | 49 taps of 12 bits, row-major |

## Verification
The assertions assume that cfg_width and cfg_kernel stay constant between resets and that cfg_width lies from 1 to the store depth. They also assume that no pixel is offered during the two cycles in which the internal reset is still being released. The bench resets the block before each configuration, holds the configuration steady, and waits several cycles before it offers pixels. It then uses random valid gaps and random downstream stalls to exercise the hold and drain paths across many widths and all kernel codes.

// File: rtl/lb_pkg.sv
package lb_pkg;
  localparam int KDIM_W = 4;

  // kernel edge from the 2-bit select, clamped to the window edge
  function automatic logic [KDIM_W-1:0] kdim_of(input logic [1:0] sel, input int unsigned kmax);
    int unsigned k;
    k = 3 + 2 * int'(sel);
    if (k > kmax) k = kmax;
    return KDIM_W'(k);
  endfunction
endpackage

// File: rtl/lb_line_store.sv
module lb_line_store #(
  parameter int PIX_W = 12,
  parameter int ROWS  = 6,
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH),
  localparam int DW   = ROWS * PIX_W
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wr_col,
  output logic [DW-1:0] rd_col
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[addr] <= wr_col;
  end

  assign rd_col = mem_q[addr];
endmodule

// File: rtl/lb_scan_ctrl.sv
module lb_scan_ctrl #(
  parameter int KMAX  = 7,
  parameter int MAX_W = 1024,
  localparam int AW   = $clog2(MAX_W),
  localparam int CW   = $clog2(MAX_W + 1),
  localparam int RW   = $clog2(KMAX),
  localparam int KW   = lb_pkg::KDIM_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          advance,
  input  logic [CW-1:0] cfg_width,
  input  logic [KW-1:0] kdim,
  output logic [AW-1:0] col_o,
  output logic          win_full_o
);
  logic [AW-1:0] col_q, col_d;
  logic [RW-1:0] rows_q, rows_d;
  logic          last_col;

  assign last_col = ({1'b0, col_q} == (cfg_width - CW'(1)));

  always_comb begin
    col_d  = col_q;
    rows_d = rows_q;
    if (advance) begin
      if (last_col) begin
        col_d = '0;
        if (rows_q != RW'(KMAX - 1)) rows_d = rows_q + RW'(1);
      end else begin
        col_d = col_q + AW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q  <= '0;
      rows_q <= '0;
    end else if (advance) begin
      col_q  <= col_d;
      rows_q <= rows_d;
    end
  end

  assign col_o      = col_q;
  assign win_full_o = (int'(rows_q) >= int'(kdim) - 1) && (int'(col_q) >= int'(kdim) - 1);
endmodule

// File: rtl/lb_window_regs.sv
module lb_window_regs #(
  parameter int PIX_W = 12,
  parameter int KMAX  = 7,
  localparam int KW   = lb_pkg::KDIM_W
) (
  input  logic                          clk,
  input  logic                          shift_en,
  input  logic [KMAX*PIX_W-1:0]         col_in,
  input  logic [KW-1:0]                 kdim,
  output logic [KMAX*KMAX*PIX_W-1:0]    win_out
);
  logic [PIX_W-1:0] tap_q [KMAX][KMAX];

  for (genvar r = 0; r < KMAX; r++) begin : g_row
    for (genvar c = 0; c < KMAX; c++) begin : g_col
      if (c == KMAX - 1) begin : g_edge
        always_ff @(posedge clk) begin
          if (shift_en) tap_q[r][c] <= col_in[r*PIX_W +: PIX_W];
        end
      end else begin : g_inner
        always_ff @(posedge clk) begin
          if (shift_en) tap_q[r][c] <= tap_q[r][c+1];
        end
      end
      logic active;
      assign active = (r >= KMAX - int'(kdim)) && (c >= KMAX - int'(kdim));
      assign win_out[(r*KMAX+c)*PIX_W +: PIX_W] = active ? tap_q[r][c] : '0;
    end
  end
endmodule

// File: rtl/lb_sliding_window.sv
module lb_sliding_window #(
  parameter int PIX_W = 12,
  parameter int KMAX  = 7,
  parameter int MAX_W = 1024,
  localparam int AW   = $clog2(MAX_W),
  localparam int CW   = $clog2(MAX_W + 1),
  localparam int KW   = lb_pkg::KDIM_W,
  localparam int WIN_W = KMAX * KMAX * PIX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CW-1:0]    cfg_width,
  input  logic [1:0]       cfg_kernel,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_pixel,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIN_W-1:0] out_window
);
  localparam int ROWS = KMAX - 1;

  logic [1:0]               rst_sync_q;
  logic                     rst_int_n;
  logic [KW-1:0]            kdim;
  logic                     accept;
  logic [AW-1:0]            col;
  logic                     win_full;
  logic [ROWS*PIX_W-1:0]    rd_col;
  logic [KMAX*PIX_W-1:0]    col_vec;
  logic                     valid_q, valid_d;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign kdim     = lb_pkg::kdim_of(cfg_kernel, KMAX);
  assign in_ready = !valid_q || out_ready;
  assign accept   = in_valid && in_ready && rst_int_n;

  // oldest stored row at the bottom slot, newest pixel on top
  assign col_vec = {in_pixel, rd_col};

  lb_scan_ctrl #(.KMAX(KMAX), .MAX_W(MAX_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .advance    (accept),
    .cfg_width  (cfg_width),
    .kdim       (kdim),
    .col_o      (col),
    .win_full_o (win_full)
  );

  lb_line_store #(.PIX_W(PIX_W), .ROWS(ROWS), .DEPTH(MAX_W)) u_store (
    .clk    (clk),
    .wr_en  (accept),
    .addr   (col),
    .wr_col (col_vec[KMAX*PIX_W-1:PIX_W]),
    .rd_col (rd_col)
  );

  lb_window_regs #(.PIX_W(PIX_W), .KMAX(KMAX)) u_win (
    .clk      (clk),
    .shift_en (accept),
    .col_in   (col_vec),
    .kdim     (kdim),
    .win_out  (out_window)
  );

  always_comb begin
    valid_d = valid_q;
    if (accept)         valid_d = win_full;
    else if (out_ready) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          valid_q <= 1'b0;
    else if (!rst_int_n) valid_q <= 1'b0;
    else                 valid_q <= valid_d;
  end

  assign out_valid = valid_q;
endmodule

// File: rtl/lb_sliding_window_chk.sv
module lb_sliding_window_chk #(
  parameter int PIX_W = 12,
  parameter int KMAX  = 7,
  parameter int MAX_W = 1024,
  localparam int CW   = $clog2(MAX_W + 1),
  localparam int WIN_W = KMAX * KMAX * PIX_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CW-1:0]    cfg_width,
  input logic [1:0]       cfg_kernel,
  input logic             in_valid,
  input logic             in_ready,
  input logic [PIX_W-1:0] in_pixel,
  input logic             out_valid,
  input logic             out_ready,
  input logic [WIN_W-1:0] out_window
);
  localparam int BR  = (KMAX - 1) * KMAX + (KMAX - 1);
  localparam int BRL = BR - 1;

  logic take;
  assign take = in_valid && in_ready;

  always @(posedge clk) begin
    if (!rst_n) p_reset_idle_r1: assert (!out_valid);
  end

  p_newest_tap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_window[BR*PIX_W +: PIX_W] == $past(in_pixel));

  p_shift_left_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_window[BRL*PIX_W +: PIX_W] == $past(out_window[BR*PIX_W +: PIX_W]));

  p_corner_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_kernel != 2'd2 && cfg_kernel != 2'd3) |-> out_window[PIX_W-1:0] == '0);

  p_stall_closed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_window)));

  p_drain_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !take) |=> !out_valid);
endmodule

bind lb_sliding_window lb_sliding_window_chk #(.PIX_W(PIX_W), .KMAX(KMAX), .MAX_W(MAX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_width  (cfg_width),
  .cfg_kernel (cfg_kernel),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_pixel   (in_pixel),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_window (out_window)
);

// File: tb/lb_sliding_window_tb.sv
module lb_sliding_window_tb;
  localparam int PW = 12;
  localparam int KM = 7;
  localparam int WW = KM * KM * PW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [10:0]   cfg_width = 11'd8;
  logic [1:0]    cfg_kernel = 2'd2;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [PW-1:0] in_pixel = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [WW-1:0] out_window;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  lb_sliding_window u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_kernel(cfg_kernel),
    .in_valid(in_valid), .in_ready(in_ready), .in_pixel(in_pixel),
    .out_valid(out_valid), .out_ready(out_ready), .out_window(out_window)
  );

  function automatic logic [PW-1:0] pix(int y, int x);
    return PW'((y * 131 + x * 17 + 5) & 12'hFFF);
  endfunction

  function automatic int kdim(int code);
    return (code >= 2) ? 7 : 3 + 2 * code;
  endfunction

  function automatic logic [WW-1:0] exp_win(int y, int x, int k);
    logic [WW-1:0] v = '0;
    for (int r = 0; r < KM; r++)
      for (int c = 0; c < KM; c++)
        if (r >= KM - k && c >= KM - k) v[(r*KM+c)*PW +: PW] = pix(y - 6 + r, x - 6 + c);
    return v;
  endfunction

  function automatic logic [WW-1:0] act_mask(int k);
    logic [WW-1:0] m = '0;
    for (int r = 0; r < KM; r++)
      for (int c = 0; c < KM; c++)
        if (r >= KM - k && c >= KM - k) m[(r*KM+c)*PW +: PW] = '1;
    return m;
  endfunction

  task automatic check(bit ok, string req, string what, logic [WW-1:0] act, logic [WW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    repeat (2) @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid in reset", WW'(out_valid), '0);
    rst_n = 1'b1;
    #1;
    check(out_valid == 1'b0, "R1", "out_valid after reset", WW'(out_valid), '0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", WW'(in_ready), WW'(1));
    repeat (4) @(negedge clk);
  endtask

  task automatic run_case(int w, int code, int rows, int gap_pct, int stall_pct);
    int k = kdim(code);
    int bx = 0, by = 0, ey = 0, ex = 0;
    bit exp_valid = 0, took = 0, any = 0, stalled = 0;
    string tag = "R1";
    logic [WW-1:0] mask = act_mask(k);
    logic [WW-1:0] prev_win = '0;
    cfg_width = 11'(w);
    cfg_kernel = 2'(code);
    do_reset();
    while (by < rows) begin
      // outputs settled since the last rising edge
      check(out_valid == exp_valid, tag, "out_valid", WW'(out_valid), WW'(exp_valid));
      if (took)
        check(out_window[(KM*KM-1)*PW +: PW] == pix(ey, ex), "R2", "newest tap",
              WW'(out_window[(KM*KM-1)*PW +: PW]), WW'(pix(ey, ex)));
      if (exp_valid) begin
        check((out_window & mask) == exp_win(ey, ex, k), (ex < 6) ? "R6" : "R3", "window",
              out_window & mask, exp_win(ey, ex, k));
        if (k < KM)
          check((out_window & ~mask) == '0, "R4", "inactive taps", out_window & ~mask, '0);
      end
      if (stalled)
        check(out_window == prev_win, "R7", "held window", out_window, prev_win);
      prev_win = out_window;
      in_valid  = (($urandom % 100) >= gap_pct);
      out_ready = (($urandom % 100) >= stall_pct);
      in_pixel  = pix(by, bx);
      #1;
      check(in_ready == (!exp_valid || out_ready), "R7", "in_ready",
            WW'(in_ready), WW'(!exp_valid || out_ready));
      took = in_valid && in_ready;
      stalled = exp_valid && !out_ready;
      @(posedge clk);
      if (took) begin
        ey = by; ex = bx; any = 1;
        exp_valid = (by >= k - 1) && (bx >= k - 1);
        tag = "R5";
        bx++;
        if (bx == w) begin bx = 0; by++; end
      end else if (out_ready) begin
        if (exp_valid) tag = "R8";
        exp_valid = 0;
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  initial begin
    run_case(7, 2, 9, 10, 20);
    run_case(9, 2, 9, 20, 30);
    run_case(9, 1, 7, 15, 25);
    run_case(9, 0, 6, 15, 25);
    run_case(12, 0, 5, 0, 0);
    run_case(5, 1, 7, 30, 40);
    run_case(3, 0, 6, 10, 10);
    run_case(1, 0, 5, 10, 10);
    run_case(10, 3, 9, 20, 20);
    run_case(6, 2, 8, 10, 10);
    run_case(1024, 0, 3, 0, 0);
    run_case(1024, 2, 7, 5, 5);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule